// File: doc/BRIEF.md
# Charge-Injection Threshold Scan Sequencer

This block runs a threshold scan for a strip readout channel without software in the loop. Software programs a channel, a pulse count per step, and an amplitude range with a step size, then writes a start command. The sequencer issues injection strobes that always coincide with the bunch counter passing through zero. After each strobe it opens an acceptance window long enough to cover the front-end readout latency. If the selected channel reports a hit inside that window, the injection is counted once.

When a step has issued its programmed number of pulses, the hit total for that step goes into a results memory at the step index. The amplitude setting then moves up by the increment. The scan stops when the next amplitude would pass the stop value, when the increment is zero, or when the results memory is full. A processor reads the counts-per-amplitude table through a small word-addressed register interface and builds an S-curve from it.

Top module: `cal_scan_engine`

## Requirements
- R1: While reset is asserted and after it is released, `scan_busy`, `scan_done`, `inj_strobe` and `bus_rdata` are 0, `inj_amp` is 0, and a status read returns 0.
- R2: `inj_strobe` is high for exactly one cycle per injection. It is high only while a scan is running, only when `bco_in` is zero, and only while the sequencer is waiting for the next injection.
- R3: A step ends after the programmed pulse count of injections, and a pulse count of 0 behaves as 1. When the step ends, its hit total is written zero-extended into result word N, where N is the step index counted from 0 within the scan.
- R4: Each injection adds at most 1 to the step total, however many hit reports arrive in its window. Only reports whose `hit_chan` equals the programmed channel are counted.
- R5: The acceptance window covers the WIN_CYC cycles that follow the strobe cycle. Hit reports in the strobe cycle, or after the window closes, are not counted.
- R6: `inj_amp` takes the amplitude start value on start and keeps it across each step's injections. After each step it rises by the increment. The scan ends instead when the increment is 0, when start+k*increment would exceed the stop value, or when step DEPTH-1 has been written. A start value above the stop value gives one step.
- R7: Within a scan, successive strobes are exactly 2^BCO_W cycles apart. After each window the sequencer waits for the next bunch-counter zero.
- R8: A start command written while a scan is running has no effect on the running scan.
- R9: Status word (address 0x00) bit 0 is busy and bit 1 is done. The two are never both set. Done is set when the scan ends and cleared by the next start. Writing 1 to bit 0 of address 0x00 starts a scan.
- R10: Word addresses are 0x01 channel, 0x02 pulse count, 0x03 amplitude start, 0x04 amplitude stop and 0x05 increment; each reads back its zero-extended value. Result word N is read at 0x40+N. Unmapped addresses read 0. Read data appears on the clock edge that samples the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bco_in | input | BCO_W | Low bits of the system bunch counter |
| hit_valid | input | 1 | A discriminator hit report is present this cycle |
| hit_chan | input | CHAN_W | Channel number of the hit report |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| inj_strobe | output | 1 | Injection pulse request |
| inj_amp | output | AMP_W | Injection amplitude setting |
| scan_busy | output | 1 | Scan running |
| scan_done | output | 1 | Scan finished since last start |

## Verification
The case that is hardest to reach is a hit report right at a window edge. Reports on the last cycle inside the window must count, and reports one cycle later must not. The bench models the front end: it watches each strobe and schedules hit reports at fixed offsets from it. It alternates between the last inside cycle and the first outside cycle from pulse to pulse. It also sends duplicate reports and reports on the wrong channel in other steps. A second start during a running scan, a reversed amplitude range, a zero pulse count, a zero increment and a sweep that fills the results memory cover the ways a scan can end.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DW     = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_WIN  = 2'd2
  } seq_state_e;

  localparam logic [ADDR_W-1:0] A_CTRL     = 8'h00;
  localparam logic [ADDR_W-1:0] A_CHAN     = 8'h01;
  localparam logic [ADDR_W-1:0] A_PULSES   = 8'h02;
  localparam logic [ADDR_W-1:0] A_AMP_LO   = 8'h03;
  localparam logic [ADDR_W-1:0] A_AMP_HI   = 8'h04;
  localparam logic [ADDR_W-1:0] A_AMP_INC  = 8'h05;
  localparam logic [ADDR_W-1:0] A_RES_BASE = 8'h40;
endpackage

// File: rtl/cal_hitwin.sv
module cal_hitwin #(
  parameter int unsigned CHAN_W  = 7,
  parameter int unsigned WIN_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic              hit_valid_i,
  input  logic [CHAN_W-1:0] hit_chan_i,
  input  logic [CHAN_W-1:0] chan_sel_i,
  output logic              win_last_o,
  output logic              win_hit_o
);
  localparam int unsigned WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYC - 1);

  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             got_q, got_d;
  logic             match;

  assign match      = act_q && hit_valid_i && (hit_chan_i == chan_sel_i);
  assign win_last_o = act_q && (cnt_q == LAST);
  assign win_hit_o  = got_q || match;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    got_d = got_q;
    if (open_i) begin
      act_d = 1'b1;
      cnt_d = '0;
      got_d = 1'b0;
    end else if (act_q) begin
      got_d = got_q || match;
      if (cnt_q == LAST) act_d = 1'b0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      got_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      got_q <= got_d;
    end
  end
endmodule

// File: rtl/cal_resmem.sv
module cal_resmem #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32
) (
  input  logic                     clk,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] widx_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [DW-1:0]            rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic wen;
    assign wen = we_i && (widx_i == ($clog2(DEPTH))'(gi));
    always_ff @(posedge clk) begin
      if (wen) mem_q[gi] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cal_regs.sv
module cal_regs
  import cal_pkg::*;
#(
  parameter int unsigned CHAN_W = 7,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned AMP_W  = 9,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              start_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [CNT_W-1:0]  pulses_o,
  output logic [AMP_W-1:0]  amp_lo_o,
  output logic [AMP_W-1:0]  amp_hi_o,
  output logic [AMP_W-1:0]  amp_inc_o,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [IDX_W-1:0]  res_addr_o,
  input  logic [DW-1:0]     res_data_i
);
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [CNT_W-1:0]  pulses_q, pulses_d;
  logic [AMP_W-1:0]  lo_q, lo_d, hi_q, hi_d, inc_q, inc_d;
  logic [DW-1:0]     rd_q, rd_d;
  logic              wr_en, rd_en, is_res;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[DW-1:CNT_W];
  assign wr_en      = bus_sel && bus_wr;
  assign rd_en      = bus_sel && !bus_wr;
  assign is_res     = (bus_addr[ADDR_W-1:IDX_W] == A_RES_BASE[ADDR_W-1:IDX_W]);
  assign res_addr_o = bus_addr[IDX_W-1:0];
  assign start_o    = wr_en && (bus_addr == A_CTRL) && bus_wdata[0];

  assign chan_o    = chan_q;
  assign pulses_o  = pulses_q;
  assign amp_lo_o  = lo_q;
  assign amp_hi_o  = hi_q;
  assign amp_inc_o = inc_q;
  assign bus_rdata = rd_q;

  always_comb begin
    chan_d   = chan_q;
    pulses_d = pulses_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    inc_d    = inc_q;
    if (wr_en) begin
      case (bus_addr)
        A_CHAN:    chan_d   = bus_wdata[CHAN_W-1:0];
        A_PULSES:  pulses_d = bus_wdata[CNT_W-1:0];
        A_AMP_LO:  lo_d     = bus_wdata[AMP_W-1:0];
        A_AMP_HI:  hi_d     = bus_wdata[AMP_W-1:0];
        A_AMP_INC: inc_d    = bus_wdata[AMP_W-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_d = '0;
    if (is_res) begin
      rd_d = res_data_i;
    end else begin
      case (bus_addr)
        A_CTRL:    rd_d = {{(DW-2){1'b0}}, done_i, busy_i};
        A_CHAN:    rd_d = DW'(chan_q);
        A_PULSES:  rd_d = DW'(pulses_q);
        A_AMP_LO:  rd_d = DW'(lo_q);
        A_AMP_HI:  rd_d = DW'(hi_q);
        A_AMP_INC: rd_d = DW'(inc_q);
        default:   rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q   <= '0;
      pulses_q <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      inc_q    <= '0;
      rd_q     <= '0;
    end else begin
      chan_q   <= chan_d;
      pulses_q <= pulses_d;
      lo_q     <= lo_d;
      hi_q     <= hi_d;
      inc_q    <= inc_d;
      if (rd_en) rd_q <= rd_d;
    end
  end
endmodule

// File: rtl/cal_seq.sv
module cal_seq
  import cal_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned AMP_W = 9,
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     bco_zero_i,
  input  logic [CNT_W-1:0]         pulses_i,
  input  logic [AMP_W-1:0]         amp_lo_i,
  input  logic [AMP_W-1:0]         amp_hi_i,
  input  logic [AMP_W-1:0]         amp_inc_i,
  input  logic                     win_last_i,
  input  logic                     win_hit_i,
  output logic                     strobe_o,
  output logic [AMP_W-1:0]         amp_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     mem_we_o,
  output logic [$clog2(DEPTH)-1:0] mem_idx_o,
  output logic [DW-1:0]            mem_wdata_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  seq_state_e       st_q, st_d;
  logic [AMP_W-1:0] amp_q, amp_d;
  logic [IDX_W-1:0] step_q, step_d;
  logic [CNT_W-1:0] pcnt_q, pcnt_d, hcnt_q, hcnt_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] hit_total;
  logic [CNT_W:0]   pcnt_inc;
  logic [AMP_W:0]   amp_next;
  logic             last_pulse, scan_end;

  assign hit_total  = hcnt_q + CNT_W'(win_hit_i);
  assign pcnt_inc   = {1'b0, pcnt_q} + (CNT_W+1)'(1);
  assign last_pulse = pcnt_inc >= {1'b0, pulses_i};
  assign amp_next   = {1'b0, amp_q} + {1'b0, amp_inc_i};
  assign scan_end   = (amp_inc_i == '0) || (amp_next > {1'b0, amp_hi_i}) || (step_q == LAST_IDX);

  assign strobe_o    = (st_q == ST_ARM) && bco_zero_i;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign amp_o       = amp_q;
  assign mem_idx_o   = step_q;
  assign mem_wdata_o = DW'(hit_total);

  always_comb begin
    st_d     = st_q;
    amp_d    = amp_q;
    step_d   = step_q;
    pcnt_d   = pcnt_q;
    hcnt_d   = hcnt_q;
    done_d   = done_q;
    mem_we_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_ARM;
          amp_d  = amp_lo_i;
          step_d = '0;
          pcnt_d = '0;
          hcnt_d = '0;
          done_d = 1'b0;
        end
      end
      ST_ARM: begin
        if (bco_zero_i) st_d = ST_WIN;
      end
      ST_WIN: begin
        if (win_last_i) begin
          st_d = ST_ARM;
          if (last_pulse) begin
            mem_we_o = 1'b1;
            pcnt_d   = '0;
            hcnt_d   = '0;
            if (scan_end) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else begin
              amp_d  = amp_next[AMP_W-1:0];
              step_d = step_q + 1'b1;
            end
          end else begin
            pcnt_d = pcnt_inc[CNT_W-1:0];
            hcnt_d = hit_total;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      amp_q  <= '0;
      step_q <= '0;
      pcnt_q <= '0;
      hcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      amp_q  <= amp_d;
      step_q <= step_d;
      pcnt_q <= pcnt_d;
      hcnt_q <= hcnt_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/cal_scan_engine.sv
module cal_scan_engine
  import cal_pkg::*;
#(
  parameter int unsigned BCO_W   = 8,
  parameter int unsigned CHAN_W  = 7,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned AMP_W   = 9,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned WIN_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BCO_W-1:0]  bco_in,
  input  logic              hit_valid,
  input  logic [CHAN_W-1:0] hit_chan,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              inj_strobe,
  output logic [AMP_W-1:0]  inj_amp,
  output logic              scan_busy,
  output logic              scan_done
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic              start, bco_zero, win_last, win_hit, mem_we;
  logic [CHAN_W-1:0] chan_sel;
  logic [CNT_W-1:0]  pulses;
  logic [AMP_W-1:0]  amp_lo, amp_hi, amp_inc;
  logic [IDX_W-1:0]  mem_idx, res_addr;
  logic [DW-1:0]     mem_wdata, res_data;

  assign bco_zero = (bco_in == '0);

  cal_regs #(.CHAN_W(CHAN_W), .CNT_W(CNT_W), .AMP_W(AMP_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .start_o(start), .chan_o(chan_sel), .pulses_o(pulses),
    .amp_lo_o(amp_lo), .amp_hi_o(amp_hi), .amp_inc_o(amp_inc),
    .busy_i(scan_busy), .done_i(scan_done),
    .res_addr_o(res_addr), .res_data_i(res_data)
  );

  cal_seq #(.CNT_W(CNT_W), .AMP_W(AMP_W), .DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bco_zero_i(bco_zero),
    .pulses_i(pulses), .amp_lo_i(amp_lo), .amp_hi_i(amp_hi), .amp_inc_i(amp_inc),
    .win_last_i(win_last), .win_hit_i(win_hit),
    .strobe_o(inj_strobe), .amp_o(inj_amp), .busy_o(scan_busy), .done_o(scan_done),
    .mem_we_o(mem_we), .mem_idx_o(mem_idx), .mem_wdata_o(mem_wdata)
  );

  cal_hitwin #(.CHAN_W(CHAN_W), .WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .open_i(inj_strobe),
    .hit_valid_i(hit_valid), .hit_chan_i(hit_chan), .chan_sel_i(chan_sel),
    .win_last_o(win_last), .win_hit_o(win_hit)
  );

  cal_resmem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .we_i(mem_we), .widx_i(mem_idx), .wdata_i(mem_wdata),
    .raddr_i(res_addr), .rdata_o(res_data)
  );
endmodule

// File: rtl/cal_scan_checker.sv
module cal_scan_checker #(
  parameter int unsigned BCO_W = 8,
  parameter int unsigned AMP_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BCO_W-1:0] bco_in,
  input logic             inj_strobe,
  input logic [AMP_W-1:0] inj_amp,
  input logic             scan_busy,
  input logic             scan_done,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [31:0]      bus_rdata
);
  localparam logic [BCO_W:0] PERIOD = (BCO_W+1)'(1) << BCO_W;

  logic [BCO_W:0] gap_q;
  logic           seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (!scan_busy) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (inj_strobe) begin
      gap_q  <= (BCO_W+1)'(1);
      seen_q <= 1'b1;
    end else if (gap_q != PERIOD) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  p_strobe_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inj_strobe |-> (bco_in == '0));

  p_strobe_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inj_strobe |-> scan_busy);

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inj_strobe |=> !inj_strobe);

  p_strobe_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_strobe && seen_q) |-> (gap_q == PERIOD));

  p_amp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inj_strobe |=> $stable(inj_amp));

  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_busy && scan_done));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind cal_scan_engine cal_scan_checker #(.BCO_W(BCO_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bco_in(bco_in), .inj_strobe(inj_strobe),
  .inj_amp(inj_amp), .scan_busy(scan_busy), .scan_done(scan_done),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rdata(bus_rdata)
);

// File: tb/cal_scan_engine_bench.sv
module cal_scan_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BCO_W = 8;
  localparam int CHAN_W = 7;
  localparam int AMP_W = 9;
  localparam int DEPTH = 16;
  localparam int WIN = 64;
  localparam int SCH = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [BCO_W-1:0]  bco;
  logic              hit_valid = 1'b0;
  logic [CHAN_W-1:0] hit_chan = '0;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              inj_strobe, scan_busy, scan_done;
  logic [AMP_W-1:0]  inj_amp;

  cal_scan_engine u_cal_scan_engine (
    .clk(clk), .rst_n(rst_n), .bco_in(bco), .hit_valid(hit_valid), .hit_chan(hit_chan),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .inj_strobe(inj_strobe), .inj_amp(inj_amp),
    .scan_busy(scan_busy), .scan_done(scan_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bco <= '0;
    else        bco <= bco + 1'b1;
  end

  int  n_tests = 0, n_fail = 0;
  bit  finished = 0;
  int  cyc = 0;
  int  n_strobe = 0;
  int  sched [SCH];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  int c_chan = 0, c_pulses = 0, c_lo = 0, c_hi = 0, c_inc = 0;
  bit m_busy = 0, m_done = 0, m_armed = 0, m_got = 0;
  int m_amp = 0, m_left = 0, m_pd = 0, m_hits = 0, m_step = 0;
  int m_res [DEPTH];

  always @(posedge clk) begin : ref_model
    bit start_w, match;
    int total, nxt, need;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_armed = 0; m_got = 0;
      m_amp = 0; m_left = 0; m_pd = 0; m_hits = 0; m_step = 0;
      c_chan = 0; c_pulses = 0; c_lo = 0; c_hi = 0; c_inc = 0;
    end else begin
      start_w = bus_sel && bus_wr && (bus_addr == 8'h00) && bus_wdata[0];
      match   = hit_valid && (int'(hit_chan) == c_chan);
      if (!m_busy) begin
        if (start_w) begin
          m_busy = 1; m_done = 0; m_armed = 1; m_amp = c_lo;
          m_step = 0; m_pd = 0; m_hits = 0;
        end
      end else if (m_armed) begin
        if (bco == 0) begin m_armed = 0; m_left = WIN; m_got = 0; end
      end else begin
        if (match) m_got = 1;
        m_left--;
        if (m_left == 0) begin
          total = m_hits + int'(m_got);
          m_pd++;
          need = (c_pulses == 0) ? 1 : c_pulses;
          m_armed = 1;
          if (m_pd >= need) begin
            m_res[m_step] = total; m_hits = 0; m_pd = 0;
            nxt = m_amp + c_inc;
            if (c_inc == 0 || nxt > c_hi || m_step == DEPTH-1) begin
              m_busy = 0; m_done = 1; m_armed = 0;
            end else begin
              m_amp = nxt; m_step++;
            end
          end else m_hits = total;
        end
      end
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          8'h01: c_chan   = int'(bus_wdata[CHAN_W-1:0]);
          8'h02: c_pulses = int'(bus_wdata[15:0]);
          8'h03: c_lo     = int'(bus_wdata[AMP_W-1:0]);
          8'h04: c_hi     = int'(bus_wdata[AMP_W-1:0]);
          8'h05: c_inc    = int'(bus_wdata[AMP_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  // ---------------- per-clock compare and front-end emulation ----------------
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 strobe", 32'(inj_strobe), 32'(m_busy && m_armed && bco == 0));
      check("R6 amp", 32'(inj_amp), 32'(m_amp));
      check("R9 busy", 32'(scan_busy), 32'(m_busy));
      check("R9 done", 32'(scan_done), 32'(m_done));
      if (inj_strobe) begin
        if (inj_amp >= 140) begin
          sched[(cyc + 1 + 10) % SCH] = c_chan;
          sched[(cyc + 1 + 20) % SCH] = c_chan;
        end else if (inj_amp >= 120) begin
          if (n_strobe % 2 == 1) sched[(cyc + 1 + WIN - 1) % SCH] = c_chan;
          else                   sched[(cyc + 1 + WIN) % SCH] = c_chan;
        end else begin
          sched[(cyc + 1 + 5) % SCH] = c_chan + 1;
        end
        n_strobe++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    #2;
    if (sched[cyc % SCH] >= 0) begin
      hit_valid = 1'b1;
      hit_chan  = CHAN_W'(sched[cyc % SCH]);
      sched[cyc % SCH] = -1;
    end else begin
      hit_valid = 1'b0;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk); #2;
    bus_sel = 0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (scan_busy) @(negedge clk);
  endtask

  task automatic config_scan(int ch, int np, int lo, int hi, int inc);
    bus_write(8'h01, 32'(ch));
    bus_write(8'h02, 32'(np));
    bus_write(8'h03, 32'(lo));
    bus_write(8'h04, 32'(hi));
    bus_write(8'h05, 32'(inc));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int s0, sum;
    for (int i = 0; i < SCH; i++) sched[i] = -1;
    for (int i = 0; i < DEPTH; i++) m_res[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy in reset", 32'(scan_busy), 0);
    check("R1 done in reset", 32'(scan_done), 0);
    check("R1 strobe in reset", 32'(inj_strobe), 0);
    check("R1 amp in reset", 32'(inj_amp), 0);
    check("R1 rdata in reset", bus_rdata, 0);
    @(posedge clk); #2; rst_n = 1;
    bus_read(8'h00, rd);
    check("R1 status after reset", rd, 0);

    // scan A: four steps, mixed hit patterns
    config_scan(5, 4, 100, 160, 20);
    bus_read(8'h01, rd); check("R10 chan readback", rd, 5);
    bus_read(8'h02, rd); check("R10 pulses readback", rd, 4);
    bus_read(8'h03, rd); check("R10 start readback", rd, 100);
    bus_read(8'h04, rd); check("R10 stop readback", rd, 160);
    bus_read(8'h05, rd); check("R10 inc readback", rd, 20);
    bus_write(8'h00, 1);
    bus_read(8'h00, rd); check("R9 status busy", rd, 1);
    repeat (600) @(posedge clk);
    bus_write(8'h00, 1);  // R8: ignored while running
    wait_idle();
    check("R8 strobes in scan A", 32'(n_strobe), 16);
    bus_read(8'h00, rd); check("R9 status done", rd, 2);
    begin
      int expa [4] = '{0, 2, 4, 4};
      for (int i = 0; i < 4; i++) begin
        bus_read(8'h40 + 8'(i), rd);
        check("R3 result vs model", rd, 32'(m_res[i]));
        check("R4 R5 result table", rd, 32'(expa[i]));
      end
    end

    // scan B: zero pulse count, start above stop
    config_scan(5, 0, 150, 5, 7);
    s0 = n_strobe;
    bus_write(8'h00, 1);
    bus_read(8'h00, rd); check("R9 done cleared on start", rd, 1);
    wait_idle();
    check("R3 zero pulses acts as one", 32'(n_strobe - s0), 1);
    bus_read(8'h40, rd); check("R3 scan B result", rd, 1);

    // scan C: fill the results memory
    config_scan(5, 1, 130, 500, 1);
    s0 = n_strobe;
    bus_write(8'h00, 1);
    wait_idle();
    check("R6 memory full step count", 32'(n_strobe - s0), DEPTH);
    check("R6 final amp", 32'(inj_amp), 32'(130 + DEPTH - 1));
    sum = 0;
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(8'h40 + 8'(i), rd);
      check("R3 scan C result vs model", rd, 32'(m_res[i]));
      sum += int'(rd);
    end
    check("R5 window edge total", 32'(sum), 11);

    // scan D: zero increment, duplicates in window
    config_scan(5, 2, 200, 300, 0);
    s0 = n_strobe;
    bus_write(8'h00, 1);
    wait_idle();
    check("R6 zero increment single step", 32'(n_strobe - s0), 2);
    bus_read(8'h40, rd); check("R4 one count per injection", rd, 2);

    bus_read(8'h3F, rd); check("R10 unmapped reads zero", rd, 0);
    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule